// File: doc/BRIEF.md
# Register-Driven NAND Flash Access Sequencer

This block lets a host processor drive a NAND flash device one bus cycle at a time through four registers on a simple synchronous register bus. The host picks the signal pattern (chip enable, two chip-select bits, ALE, CLE and a write-enable gate) in a mode register. It then reads or writes a data register, and each such access runs exactly one external read or write cycle. Every control bit except chip enable goes through an external control latch. That latch is loaded only by the latch strobe, which fires at the start of every data-register access.

The host holds `sel_i` and its address, direction and write data until it samples `ready_o` high at a clock edge. A data-register access keeps the host waiting until the whole external cycle is over. The cycle is one latch-strobe clock, then a data strobe of programmed width, then a programmed hold. Writing any value to the reset register returns the whole controller to its initial state. Writing zero to the mode register and then writing the data register gives a latch-only cycle. Software uses this to clear the latch, or to wait after dropping ALE before the next read strobe.

Top module: `nand_seq_top`

## Requirements
- R1: A host write to address 0 sets the timing register, the mode register and the sequencer back to their reset values. After the access `ce_o` is 0, both registers read back as 0, and a following data write completes with the minimum latency of 5 cycles.
- R2: A write to the mode register (address 2) completes with `ready_o` 2 cycles after the request. `ce_o` follows mode bit 0 from the next cycle. No latch strobe is produced.
- R3: Every data-register access (address 3) starts with exactly one clock of `latch_stb_o`, before any data strobe. During that clock `latch_d_o` carries mode bits {5?no: cs[1:0] from mode bits 2:1, CLE from mode bit 4, ALE from mode bit 3} packed as latch_d_o[3:2]=cs, [1]=CLE, [0]=ALE. Mode writes alone never update the latch.
- R4: A data-register read holds `nand_re_no` low for PW+1 cycles, where PW is timing bits 3:0. During a read `nand_we_no` stays high and `dq_oe_o` stays low. `rdata_o` returns `dq_i` as captured at the end of the read strobe.
- R5: A data-register write holds `nand_we_no` low for PW+1 cycles when ALE (mode bit 3), CLE (mode bit 4) or WE (mode bit 5) is set. Otherwise `nand_we_no` stays high. With all three clear the access is a latch-only cycle.
- R6: After the data strobe the bus is held for HD+1 cycles, where HD is timing bits 7:4. `ready_o` then rises, so a data access completes 5+PW+HD cycles after the request.
- R7: During a data write `dq_oe_o` is high for 3+PW+HD cycles, from the latch clock through the end of the hold. `dq_o` carries the low byte of the host write data.
- R8: Host reads of the timing (address 1) and mode (address 2) registers return the stored values with a latency of 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Host request, held until ready_o |
| wr_i | input | 1 | Host direction, 1 = write |
| addr_i | input | 2 | Register address: 0 reset, 1 timing, 2 mode, 3 data |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data, valid with ready_o |
| ready_o | output | 1 | One-cycle access completion |
| ce_o | output | 1 | NAND chip enable, direct from mode bit 0 |
| latch_stb_o | output | 1 | External control-latch load strobe |
| latch_d_o | output | 4 | Latch contents: {cs[1:0], CLE, ALE} |
| nand_we_no | output | 1 | Active-low NAND write strobe |
| nand_re_no | output | 1 | Active-low NAND read strobe |
| dq_o | output | 8 | NAND data bus out |
| dq_oe_o | output | 1 | NAND data bus output enable |
| dq_i | input | 8 | NAND data bus in |

## Verification
A wrong sequencer state shows at the ports within the same access. A lost or repeated latch clock, or a strobe count that is off, changes the number of low strobe cycles or the cycle at which `ready_o` rises. A stale mode or timing register shows as wrong latch contents or a wrong strobe length on the very next data access. A wrong read capture returns the wrong byte with `ready_o`. The sweep covers every pulse width and hold time in 0..3 against all ALE/CLE/WE combinations in both directions, so an off-by-one in either counter or in the write gating shows within a few dozen cycles.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam logic [1:0] A_RST  = 2'd0;
  localparam logic [1:0] A_TIM  = 2'd1;
  localparam logic [1:0] A_MODE = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_LATCH,
    ST_STRB,
    ST_HOLD
  } seq_st_e;

  typedef struct packed {
    logic       we;
    logic       cle;
    logic       ale;
    logic [1:0] cs;
    logic       ce;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int PW_W   = 4,
  parameter int HD_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              tim_wr_i,
  input  logic              mode_wr_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic [PW_W-1:0]   pw_o,
  output logic [HD_W-1:0]   hd_o,
  output mode_t             mode_o
);
  localparam int TIM_W = PW_W + HD_W;

  logic [PW_W-1:0] pw_q;
  logic [HD_W-1:0] hd_q;
  mode_t           mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_q   <= '0;
      hd_q   <= '0;
      mode_q <= '0;
    end else if (soft_rst_i) begin
      pw_q   <= '0;
      hd_q   <= '0;
      mode_q <= '0;
    end else begin
      if (tim_wr_i) begin
        pw_q <= wdata_i[PW_W-1:0];
        hd_q <= wdata_i[TIM_W-1:PW_W];
      end
      if (mode_wr_i) mode_q <= mode_t'(wdata_i[MODE_W-1:0]);
    end
  end

  assign pw_o   = pw_q;
  assign hd_o   = hd_q;
  assign mode_o = mode_q;

  assert_ce_immediate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr_i && !soft_rst_i) |=> (mode_o.ce == $past(wdata_i[0])));

  assert_soft_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (mode_o == '0 && pw_o == '0 && hd_o == '0));
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int DW     = 8,
  parameter int PW_W   = 4,
  parameter int HD_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [HOST_W-1:0] wdata_i,
  input  logic [PW_W-1:0]   pw_i,
  input  logic [HD_W-1:0]   hd_i,
  input  mode_t             mode_i,
  input  logic [DW-1:0]     dq_i,
  output logic              soft_rst_o,
  output logic              tim_wr_o,
  output logic              mode_wr_o,
  output logic              ready_o,
  output logic [HOST_W-1:0] rdata_o,
  output logic              latch_stb_o,
  output logic              we_no,
  output logic              re_no,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o
);
  localparam int CNT_W = (PW_W > HD_W) ? PW_W : HD_W;

  seq_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              is_wr_q;
  logic              we_en_q;
  logic [DW-1:0]     dq_q;
  logic [HOST_W-1:0] rdata_q;
  logic [HOST_W-1:0] rb;
  logic              acc;

  assign acc        = sel_i && (st_q == ST_IDLE);
  assign soft_rst_o = acc && wr_i && (addr_i == A_RST);
  assign tim_wr_o   = acc && wr_i && (addr_i == A_TIM);
  assign mode_wr_o  = acc && wr_i && (addr_i == A_MODE);

  always_comb begin
    rb = '0;
    case (addr_i)
      A_TIM:   rb = HOST_W'({hd_i, pw_i});
      A_MODE:  rb = HOST_W'(mode_i);
      default: rb = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      is_wr_q <= 1'b0;
      we_en_q <= 1'b0;
      dq_q    <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (sel_i) begin
          is_wr_q <= wr_i;
          if (addr_i == A_DATA) begin
            st_q    <= ST_LATCH;
            we_en_q <= mode_i.ale | mode_i.cle | mode_i.we;
            if (wr_i) dq_q <= wdata_i[DW-1:0];
          end else begin
            st_q <= ST_ACK;
            if (!wr_i) rdata_q <= rb;
            if (wr_i && addr_i == A_RST) begin
              dq_q    <= '0;
              rdata_q <= '0;
              cnt_q   <= '0;
              we_en_q <= 1'b0;
            end
          end
        end
        ST_LATCH: begin
          st_q  <= ST_STRB;
          cnt_q <= CNT_W'(pw_i);
        end
        ST_STRB: begin
          if (cnt_q == '0) begin
            st_q  <= ST_HOLD;
            cnt_q <= CNT_W'(hd_i);
            if (!is_wr_q) rdata_q <= HOST_W'(dq_i);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) st_q <= ST_ACK;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_ACK:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = (st_q == ST_ACK);
  assign rdata_o     = rdata_q;
  assign latch_stb_o = (st_q == ST_LATCH);
  assign we_no       = !((st_q == ST_STRB) && is_wr_q && we_en_q);
  assign re_no       = !((st_q == ST_STRB) && !is_wr_q);
  assign dq_o        = dq_q;
  assign dq_oe_o     = is_wr_q && (st_q == ST_LATCH || st_q == ST_STRB || st_q == ST_HOLD);

  assert_latch_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_stb_o |=> !latch_stb_o);

  assert_we_after_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |-> $past(latch_stb_o));

  assert_re_after_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(re_no) |-> $past(latch_stb_o));

  assert_read_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> (we_no && !dq_oe_o));

  assert_ready_bus_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (we_no && re_no && !latch_stb_o && !dq_oe_o));

  assert_oe_covers_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> dq_oe_o);
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int DW     = 8,
  parameter int PW_W   = 4,
  parameter int HD_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic [HOST_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              ce_o,
  output logic              latch_stb_o,
  output logic [3:0]        latch_d_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o,
  input  logic [DW-1:0]     dq_i
);
  logic            soft_rst, tim_wr, mode_wr;
  logic [PW_W-1:0] pw;
  logic [HD_W-1:0] hd;
  mode_t           mode;

  nand_seq_regs #(.HOST_W(HOST_W), .PW_W(PW_W), .HD_W(HD_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst),
    .tim_wr_i   (tim_wr),
    .mode_wr_i  (mode_wr),
    .wdata_i    (wdata_i),
    .pw_o       (pw),
    .hd_o       (hd),
    .mode_o     (mode)
  );

  nand_seq_fsm #(.HOST_W(HOST_W), .DW(DW), .PW_W(PW_W), .HD_W(HD_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_i),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .pw_i        (pw),
    .hd_i        (hd),
    .mode_i      (mode),
    .dq_i        (dq_i),
    .soft_rst_o  (soft_rst),
    .tim_wr_o    (tim_wr),
    .mode_wr_o   (mode_wr),
    .ready_o     (ready_o),
    .rdata_o     (rdata_o),
    .latch_stb_o (latch_stb_o),
    .we_no       (nand_we_no),
    .re_no       (nand_re_no),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o)
  );

  assign ce_o      = mode.ce;
  assign latch_d_o = {mode.cs, mode.cle, mode.ale};
endmodule

// File: tb/tb_nand_seq_top.sv
`timescale 1ns/1ps
module tb_nand_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ready, ce, lstb, we_n, re_n, oe;
  logic [3:0]  ld;
  logic [7:0]  dq_out, dq_in = '0;

  int checks = 0, errors = 0;
  int n_lat, n_we, n_re, n_oe, lat_k, str_k, lat_n;
  logic [3:0]  latch_model = '0;
  logic [7:0]  dq_seen;
  logic [15:0] rd;

  always #10 clk = ~clk;

  nand_seq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .ce_o(ce),
    .latch_stb_o(lstb), .latch_d_o(ld), .nand_we_no(we_n), .nand_re_no(re_n),
    .dq_o(dq_out), .dq_oe_o(oe), .dq_i(dq_in)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [1:0] a, input logic [15:0] d);
    n_lat = 0; n_we = 0; n_re = 0; n_oe = 0; lat_k = -1; str_k = -1; lat_n = -1;
    @(posedge clk); #1;
    sel = 1'b1; wr = w; addr = a; wdata = d;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      if (lstb) begin n_lat++; lat_k = k; latch_model = ld; end
      if (!we_n) begin n_we++; if (str_k < 0) str_k = k; end
      if (!re_n) begin n_re++; if (str_k < 0) str_k = k; end
      if (oe) begin n_oe++; dq_seen = dq_out; end
      if (ready) begin lat_n = k; rd = rdata; break; end
    end
    if (lat_n < 0) begin
      errors++;
      $display("FAIL access watchdog actual=no_ready expected=ready");
    end
    @(posedge clk); #1;
    sel = 1'b0;
  endtask

  initial begin
    logic [15:0] mw;
    logic [3:0]  exp_l;
    logic        gate;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset ready", int'(ready), 0);
    chk("R1 reset ce", int'(ce), 0);
    chk("R1 reset strobes", int'({lstb, we_n, re_n, oe}), 6);
    rst_n = 1'b1;

    // mode write: ce=1, cs=2, ale=1
    xfer(1'b1, 2'd2, 16'h000D);
    chk("R2 mode latency", lat_n, 2);
    chk("R2 ce follows", int'(ce), 1);
    chk("R2 no latch strobe", n_lat, 0);
    chk("R3 latch untouched", int'(latch_model), 0);

    for (int pw = 0; pw < 4; pw++) begin
      for (int hd = 0; hd < 4; hd++) begin
        xfer(1'b1, 2'd1, 16'(hd * 16 + pw));
        xfer(1'b0, 2'd1, 16'h0);
        chk("R8 timing readback", int'(rd), hd * 16 + pw);
        chk("R8 read latency", lat_n, 2);
        for (int m = 0; m < 8; m++) begin
          mw = 16'({m[2], m[1], m[0], m[1:0] ^ 2'b01, 1'b1});
          exp_l = {m[1:0] ^ 2'b01, m[1], m[0]};
          gate = (m != 0);
          xfer(1'b1, 2'd2, mw);
          xfer(1'b0, 2'd2, 16'h0);
          chk("R8 mode readback", int'(rd), int'(mw));
          xfer(1'b1, 2'd3, 16'(16'hA500 + pw * 37 + hd * 11 + m));
          chk("R3 one latch clock", n_lat, 1);
          chk("R3 latch contents", int'(latch_model), int'(exp_l));
          chk("R5 write strobe length", n_we, gate ? pw + 1 : 0);
          if (gate) chk("R3 latch before strobe", int'(str_k > lat_k), 1);
          chk("R7 oe length", n_oe, 3 + pw + hd);
          chk("R7 dq data", int'(dq_seen), (pw * 37 + hd * 11 + m) & 8'hFF);
          chk("R6 write latency", lat_n, 5 + pw + hd);
          dq_in = 8'(8'h3C ^ (pw * 16 + hd * 4 + m));
          xfer(1'b0, 2'd3, 16'h0);
          chk("R4 read strobe length", n_re, pw + 1);
          chk("R4 no we on read", n_we, 0);
          chk("R4 no oe on read", n_oe, 0);
          chk("R4 read data", int'(rd), int'(dq_in));
          chk("R3 latch before read", int'(str_k > lat_k), 1);
          chk("R6 read latency", lat_n, 5 + pw + hd);
        end
      end
    end

    // latch-clear cycle
    xfer(1'b1, 2'd2, 16'h0000);
    xfer(1'b1, 2'd3, 16'h00FF);
    chk("R5 latch-only no we", n_we, 0);
    chk("R5 latch cleared", int'(latch_model), 0);
    chk("R3 latch-only pulse", n_lat, 1);

    // soft reset
    xfer(1'b1, 2'd1, 16'h0033);
    xfer(1'b1, 2'd2, 16'h0001);
    xfer(1'b1, 2'd0, 16'h1234);
    chk("R1 soft reset latency", lat_n, 2);
    chk("R1 ce cleared", int'(ce), 0);
    xfer(1'b0, 2'd2, 16'h0);
    chk("R1 mode cleared", int'(rd), 0);
    xfer(1'b0, 2'd1, 16'h0);
    chk("R1 timing cleared", int'(rd), 0);
    xfer(1'b1, 2'd3, 16'h0055);
    chk("R1 min latency", lat_n, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL global watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule